// File: doc/BRIEF.md
# Self-Selecting Parallel Host Port

This block is the processor-facing front end of a byte-oriented serial bus controller. A host reaches it over an 8-bit data bus, one address line, a chip select and two control pins. After reset the block treats those control pins as a pair of separate read and write strobes. It watches the first write activity to decide whether the host instead uses a single read/not-write line with an acknowledge handshake. Once chosen, that protocol holds until the next reset.

Host accesses are decoded into five register locations. Three are setup registers, normally loaded once after reset: the controller's own slave address, a clock setting and an interrupt vector. Two are used during transfers: a data location and a control/status location. Both of these are split, so a write lands in one storage element while a read returns a value supplied by the serial back-end. Each byte is handed over by polling the status or by an active-low interrupt request. The serial shifting, clock generation and arbitration logic sit behind the back-end ports and are not part of this block.

All host strobes pass through two-flop synchronizers before any edge is taken from them. The data bus is modelled as separate input, output and output-enable signals, and the acknowledge pin as an output with its own enable.

Top module: `hpi_front`

## Requirements
- R1: While reset is active and after it is released, the block drives neither the data bus nor the acknowledge pin, `host_irq_n` is 1, `mode_rw` is 0, and every configuration output and `be_tx_data` are 0.
- R2: After reset the block is in split-strobe mode (`mode_rw` = 0). If the first falling edge of `host_wr_n` after reset comes while `host_cs_n` is low, that write locks split-strobe mode. A later falling edge of `host_wr_n` while `host_cs_n` is high has no effect.
- R3: If the first falling edge of `host_wr_n` after reset comes while `host_cs_n` is high, `mode_rw` becomes 1. It stays 1 whatever the pins do until the next reset.
- R4: The acknowledge pin is enabled only in read/write-line mode, and only while the synchronized chip select is active. In the first enabled cycle it drives 1. From one clock later it drives 0 until chip select is released. In split-strobe mode it is never enabled.
- R5: A write with `host_a0` = 1 loads the control register (`cfg_ctrl`). A write with `host_a0` = 0 goes where control bits [1:0] point: 00 loads the transmit data register (`be_tx_data`) and pulses `be_tx_load` for one cycle, 01 loads the own address, 10 the clock setting and 11 the vector.
- R6: A read with `host_a0` = 1 returns `be_status`. A read with `host_a0` = 0 and selector 00 returns `be_rx_data`, not the last written data. With selector 01, 10 or 11 it returns the own address, clock setting or vector register.
- R7: In read/write-line mode an access begins when chip select falls. `host_wr_n` high at that point makes it a read, and low makes it a write.
- R8: A one-cycle `be_byte_done` pulse drives `host_irq_n` to 0 when control bit 7 (interrupt enable) is 1. When that bit is 0, the pulse leaves `host_irq_n` at 1.
- R9: A pending interrupt is cleared by any host read or write that targets the data register (`host_a0` = 0, selector 00). Accesses to other locations leave it pending.
- R10: `host_d_oe` is 1 only during a read with chip select active: `host_rd_n` low in split-strobe mode, or `host_wr_n` high in read/write-line mode. It is 0 at all other times.
- R11: A reset applied in read/write-line mode returns the block to split-strobe mode and clears all registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_cs_n | input | 1 | Chip select, active low |
| host_a0 | input | 1 | Register address line |
| host_wr_n | input | 1 | Write strobe, or read/not-write line in read/write-line mode |
| host_rd_n | input | 1 | Read strobe in split-strobe mode |
| host_d_i | input | 8 | Host data bus, input side |
| host_d_o | output | 8 | Host data bus, output side |
| host_d_oe | output | 1 | Data bus output enable |
| host_dtack_o | output | 1 | Acknowledge pin level, active low |
| host_dtack_oe | output | 1 | Acknowledge pin output enable |
| host_irq_n | output | 1 | Interrupt request, active low |
| mode_rw | output | 1 | 1 when read/write-line mode has been selected |
| be_byte_done | input | 1 | Back-end byte-complete pulse |
| be_rx_data | input | 8 | Received byte from the back-end shift path |
| be_status | input | 8 | Status byte from the back-end |
| be_tx_data | output | 8 | Byte written by the host for transmission |
| be_tx_load | output | 1 | One-cycle pulse when `be_tx_data` is loaded |
| cfg_ctrl | output | 8 | Control register contents |
| cfg_own | output | 8 | Own slave address register |
| cfg_clk | output | 8 | Clock setting register |
| cfg_vec | output | 8 | Interrupt vector register |

## Verification
The properties assume that `host_a0` and `host_d_i` are stable from before a strobe edge until that edge has passed the synchronizers. They also assume that each strobe level lasts several clocks, and that chip select and `host_wr_n` never change in the same clock. If those last two changed together, the synchronized samples could reorder them and make a write look like a bare write-line edge. The bench tasks set address and data first, then move one pin per clock edge. They hold every level for at least four clocks and leave chip select high between accesses, so every edge is seen cleanly. The random phase varies only the register targets, the data values and the back-end inputs, never this pin ordering.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  // Destination of an address-0 access, taken from control bits [1:0]
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_OWN  = 2'd1,
    SEL_CLK  = 2'd2,
    SEL_VEC  = 2'd3
  } hpi_sel_e;

  // Host protocol chosen after reset
  typedef enum logic {
    MODE_SPLIT = 1'b0,
    MODE_RW    = 1'b1
  } hpi_mode_e;
endpackage

// File: rtl/hpi_sync.sv
module hpi_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= RST_VAL;
          else        stg_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= RST_VAL;
          else        stg_q[i] <= stg_q[i-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hpi_mode_det.sv
module hpi_mode_det
  import hpi_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_fall,
  input  logic      cs_act,
  output hpi_mode_e mode
);
  logic      decided_q, decided_d;
  hpi_mode_e mode_q, mode_d;

  always_comb begin
    decided_d = decided_q;
    mode_d    = mode_q;
    if (!decided_q && wr_fall) begin
      decided_d = 1'b1;
      mode_d    = cs_act ? MODE_SPLIT : MODE_RW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decided_q <= 1'b0;
      mode_q    <= MODE_SPLIT;
    end else begin
      decided_q <= decided_d;
      mode_q    <= mode_d;
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/hpi_strobe.sv
module hpi_strobe
  import hpi_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  hpi_mode_e mode,
  input  logic      cs_n_s,
  input  logic      wr_n_s,
  input  logic      rd_n_s,
  output logic      cs_act,
  output logic      wr_fall,
  output logic      wr_evt,
  output logic      rd_evt,
  output logic      bus_oe,
  output logic      dtack_o,
  output logic      dtack_oe
);
  logic cs_prev_q, wr_prev_q, rd_prev_q, ack_q;
  logic ack_d;
  logic cs_fall, rd_fall;

  assign cs_act  = ~cs_n_s;
  assign wr_fall = wr_prev_q & ~wr_n_s;
  assign rd_fall = rd_prev_q & ~rd_n_s;
  assign cs_fall = cs_prev_q & ~cs_n_s;

  always_comb begin
    if (mode == MODE_RW) begin
      wr_evt = cs_fall & ~wr_n_s;
      rd_evt = cs_fall &  wr_n_s;
      bus_oe = cs_act  &  wr_n_s;
    end else begin
      wr_evt = wr_fall & cs_act;
      rd_evt = rd_fall & cs_act;
      bus_oe = cs_act  & ~rd_n_s;
    end
    ack_d = (mode == MODE_RW) & cs_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q <= 1'b1;
      wr_prev_q <= 1'b1;
      rd_prev_q <= 1'b1;
      ack_q     <= 1'b0;
    end else begin
      cs_prev_q <= cs_n_s;
      wr_prev_q <= wr_n_s;
      rd_prev_q <= rd_n_s;
      ack_q     <= ack_d;
    end
  end

  assign dtack_oe = (mode == MODE_RW) & cs_act;
  assign dtack_o  = ~ack_q;
endmodule

// File: rtl/hpi_regs.sv
module hpi_regs
  import hpi_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt,
  input  logic          rd_evt,
  input  logic          a0,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] rx_data,
  input  logic [DW-1:0] status,
  output logic [DW-1:0] dout,
  output logic [DW-1:0] ctrl,
  output logic [DW-1:0] own,
  output logic [DW-1:0] clkset,
  output logic [DW-1:0] vec,
  output logic [DW-1:0] tx_data,
  output logic          tx_load,
  output logic          data_touch,
  output logic          ien
);
  localparam int unsigned IEN_BIT = DW - 1;

  logic [DW-1:0] ctrl_q, own_q, clk_q, vec_q, tx_q;
  logic [DW-1:0] ctrl_d, own_d, clk_d, vec_d, tx_d;
  logic          load_q, load_d;
  hpi_sel_e      sel;

  assign sel = hpi_sel_e'(ctrl_q[1:0]);

  always_comb begin
    ctrl_d = ctrl_q;
    own_d  = own_q;
    clk_d  = clk_q;
    vec_d  = vec_q;
    tx_d   = tx_q;
    load_d = 1'b0;
    if (wr_evt) begin
      if (a0) begin
        ctrl_d = din;
      end else begin
        unique case (sel)
          SEL_DATA: begin tx_d = din; load_d = 1'b1; end
          SEL_OWN:  own_d = din;
          SEL_CLK:  clk_d = din;
          SEL_VEC:  vec_d = din;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      own_q  <= '0;
      clk_q  <= '0;
      vec_q  <= '0;
      tx_q   <= '0;
      load_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      own_q  <= own_d;
      clk_q  <= clk_d;
      vec_q  <= vec_d;
      tx_q   <= tx_d;
      load_q <= load_d;
    end
  end

  always_comb begin
    if (a0) begin
      dout = status;
    end else begin
      unique case (sel)
        SEL_DATA: dout = rx_data;
        SEL_OWN:  dout = own_q;
        SEL_CLK:  dout = clk_q;
        SEL_VEC:  dout = vec_q;
      endcase
    end
  end

  assign data_touch = (wr_evt | rd_evt) & ~a0 & (sel == SEL_DATA);
  assign ien        = ctrl_q[IEN_BIT];
  assign ctrl       = ctrl_q;
  assign own        = own_q;
  assign clkset     = clk_q;
  assign vec        = vec_q;
  assign tx_data    = tx_q;
  assign tx_load    = load_q;
endmodule

// File: rtl/hpi_irq.sv
module hpi_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_done,
  input  logic ien,
  input  logic data_touch,
  output logic irq_n
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (data_touch)       pend_d = 1'b0;
    if (byte_done && ien) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign irq_n = ~pend_q;
endmodule

// File: rtl/hpi_front.sv
module hpi_front
  import hpi_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_cs_n,
  input  logic          host_a0,
  input  logic          host_wr_n,
  input  logic          host_rd_n,
  input  logic [DW-1:0] host_d_i,
  output logic [DW-1:0] host_d_o,
  output logic          host_d_oe,
  output logic          host_dtack_o,
  output logic          host_dtack_oe,
  output logic          host_irq_n,
  output logic          mode_rw,
  input  logic          be_byte_done,
  input  logic [DW-1:0] be_rx_data,
  input  logic [DW-1:0] be_status,
  output logic [DW-1:0] be_tx_data,
  output logic          be_tx_load,
  output logic [DW-1:0] cfg_ctrl,
  output logic [DW-1:0] cfg_own,
  output logic [DW-1:0] cfg_clk,
  output logic [DW-1:0] cfg_vec
);
  localparam int unsigned NSTB = 3;

  logic            rst_sn;
  logic [NSTB-1:0] stb_s;
  hpi_mode_e       mode;
  logic            cs_act, wr_fall, wr_evt, rd_evt, bus_oe;
  logic            data_touch, ien_w;

  hpi_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sn)
  );

  hpi_sync #(.W(NSTB), .STAGES(SYNC_STAGES), .RST_VAL({NSTB{1'b1}})) u_stb_sync (
    .clk(clk), .rst_n(rst_sn), .d({host_cs_n, host_wr_n, host_rd_n}), .q(stb_s)
  );

  hpi_mode_det u_mode (
    .clk(clk), .rst_n(rst_sn), .wr_fall(wr_fall), .cs_act(cs_act), .mode(mode)
  );

  hpi_strobe u_strobe (
    .clk(clk), .rst_n(rst_sn), .mode(mode),
    .cs_n_s(stb_s[2]), .wr_n_s(stb_s[1]), .rd_n_s(stb_s[0]),
    .cs_act(cs_act), .wr_fall(wr_fall), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .bus_oe(bus_oe), .dtack_o(host_dtack_o), .dtack_oe(host_dtack_oe)
  );

  hpi_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_sn), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .a0(host_a0), .din(host_d_i), .rx_data(be_rx_data), .status(be_status),
    .dout(host_d_o), .ctrl(cfg_ctrl), .own(cfg_own), .clkset(cfg_clk),
    .vec(cfg_vec), .tx_data(be_tx_data), .tx_load(be_tx_load),
    .data_touch(data_touch), .ien(ien_w)
  );

  hpi_irq u_irq (
    .clk(clk), .rst_n(rst_sn), .byte_done(be_byte_done), .ien(ien_w),
    .data_touch(data_touch), .irq_n(host_irq_n)
  );

  assign host_d_oe = bus_oe;
  assign mode_rw   = (mode == MODE_RW);
endmodule

// File: rtl/hpi_front_chk.sv
module hpi_front_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_rw,
  input logic cs_act,
  input logic dtack_o,
  input logic dtack_oe,
  input logic d_oe,
  input logic irq_n,
  input logic byte_done,
  input logic ien,
  input logic data_touch
);
  assert_dtack_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dtack_oe |-> (mode_rw && cs_act));

  assert_dtack_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dtack_oe && $past(dtack_oe)) |-> !dtack_o);

  assert_mode_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rw |=> mode_rw);

  assert_bus_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> cs_act);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(byte_done && ien));

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(data_touch));
endmodule

bind hpi_front hpi_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_rw(mode_rw), .cs_act(cs_act),
  .dtack_o(host_dtack_o), .dtack_oe(host_dtack_oe), .d_oe(host_d_oe),
  .irq_n(host_irq_n), .byte_done(be_byte_done), .ien(ien_w),
  .data_touch(data_touch)
);

// File: tb/tb_hpi_front.sv
`timescale 1ns/1ps
module tb_hpi_front;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, a0, wr_n, rd_n, done;
  logic [7:0] d_i, rx, st;
  logic [7:0] d_o, tx, c_ctrl, c_own, c_clk, c_vec;
  logic       d_oe, dt_o, dt_oe, irq_n, mrw, tx_load;

  int n_chk = 0, n_fail = 0, n_load = 0;
  logic [7:0] m_ctrl, m_own, m_clk, m_vec, m_tx;
  int         m_load;
  bit         finished = 0;

  always #4 clk = ~clk;

  hpi_front dut (
    .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_a0(a0),
    .host_wr_n(wr_n), .host_rd_n(rd_n), .host_d_i(d_i), .host_d_o(d_o),
    .host_d_oe(d_oe), .host_dtack_o(dt_o), .host_dtack_oe(dt_oe),
    .host_irq_n(irq_n), .mode_rw(mrw), .be_byte_done(done),
    .be_rx_data(rx), .be_status(st), .be_tx_data(tx), .be_tx_load(tx_load),
    .cfg_ctrl(c_ctrl), .cfg_own(c_own), .cfg_clk(c_clk), .cfg_vec(c_vec)
  );

  always @(posedge clk) if (tx_load === 1'b1) n_load++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input bit addr);
    if (addr) return st;
    case (m_ctrl[1:0])
      2'd0:    return rx;
      2'd1:    return m_own;
      2'd2:    return m_clk;
      default: return m_vec;
    endcase
  endfunction

  task automatic model_wr(input bit addr, input logic [7:0] v);
    if (addr) m_ctrl = v;
    else case (m_ctrl[1:0])
      2'd0: begin m_tx = v; m_load++; end
      2'd1: m_own = v;
      2'd2: m_clk = v;
      default: m_vec = v;
    endcase
  endtask

  task automatic chk_cfg(input string tag);
    chk({tag, " ctrl"}, c_ctrl, m_ctrl);
    chk({tag, " own"},  c_own,  m_own);
    chk({tag, " clk"},  c_clk,  m_clk);
    chk({tag, " vec"},  c_vec,  m_vec);
    chk({tag, " tx"},   tx,     m_tx);
    chk({tag, " loads"}, n_load, m_load);
  endtask

  task automatic do_reset();
    cs_n = 1; wr_n = 1; rd_n = 1; a0 = 0; d_i = 0; done = 0;
    rst_n = 0;
    tick(3);
    rst_n = 1;
    tick(4);
    m_ctrl = 0; m_own = 0; m_clk = 0; m_vec = 0; m_tx = 0;
  endtask

  task automatic sp_wr(input bit addr, input logic [7:0] v);
    a0 = addr; d_i = v;
    cs_n = 0; tick(1);
    wr_n = 0; tick(4);
    wr_n = 1; tick(1);
    cs_n = 1; tick(4);
    model_wr(addr, v);
  endtask

  task automatic sp_rd(input bit addr, input string tag);
    a0 = addr;
    cs_n = 0; tick(1);
    rd_n = 0; tick(4);
    chk({tag, " oe"}, d_oe, 1'b1);
    chk({tag, " data"}, d_o, exp_rd(addr));
    rd_n = 1; tick(1);
    cs_n = 1; tick(4);
    chk({tag, " oe off R10"}, d_oe, 1'b0);
  endtask

  task automatic rw_wr(input bit addr, input logic [7:0] v);
    a0 = addr; d_i = v;
    wr_n = 0; tick(1);
    cs_n = 0; tick(4);
    chk("R10 no drive on write", d_oe, 1'b0);
    cs_n = 1; tick(1);
    wr_n = 1; tick(4);
    model_wr(addr, v);
  endtask

  task automatic rw_rd(input bit addr, input string tag);
    a0 = addr; wr_n = 1; tick(1);
    cs_n = 0; tick(4);
    chk({tag, " oe"}, d_oe, 1'b1);
    chk({tag, " data"}, d_o, exp_rd(addr));
    cs_n = 1; tick(4);
  endtask

  task automatic pulse_done();
    done = 1; tick(1);
    done = 0; tick(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    m_load = 0;
    rx = 8'h5A; st = 8'hC3;
    cs_n = 1; wr_n = 1; rd_n = 1; a0 = 0; d_i = 0; done = 0;
    rst_n = 0;
    tick(2);
    // R1: outputs while reset is held
    chk("R1 irq in reset", irq_n, 1'b1);
    chk("R1 oe in reset", d_oe, 1'b0);
    chk("R1 dtack oe in reset", dt_oe, 1'b0);
    do_reset();
    chk("R1 mode", mrw, 1'b0);
    chk("R1 irq", irq_n, 1'b1);
    chk("R1 dtack oe", dt_oe, 1'b0);
    chk_cfg("R1");

    // R2: a chip-selected write locks split mode
    sp_wr(1'b1, 8'h01);
    chk("R2 mode after write", mrw, 1'b0);
    wr_n = 0; tick(4); wr_n = 1; tick(4);
    chk("R2 bare edge ignored", mrw, 1'b0);
    chk_cfg("R2");

    // R5/R6: setup registers through the selector
    sp_wr(1'b0, 8'h4E); sp_wr(1'b1, 8'h02);
    sp_wr(1'b0, 8'h1C); sp_wr(1'b1, 8'h03);
    sp_wr(1'b0, 8'hB7);
    chk_cfg("R5 setup");
    sp_rd(1'b0, "R6 vec read");
    sp_wr(1'b1, 8'h01); sp_rd(1'b0, "R6 own read");
    sp_wr(1'b1, 8'h00); sp_wr(1'b0, 8'hE1);
    chk_cfg("R5 data");
    sp_rd(1'b0, "R6 rx not tx");
    sp_rd(1'b1, "R6 status");

    // R10/R4: strobe without chip select, and no acknowledge in split mode
    rd_n = 0; tick(4);
    chk("R10 no cs", d_oe, 1'b0);
    rd_n = 1; cs_n = 0; tick(4);
    chk("R4 split mode", dt_oe, 1'b0);
    cs_n = 1; tick(4);

    // random traffic, split mode (R5 R6)
    for (int i = 0; i < 40; i++) begin
      int unsigned op = $urandom % 4;
      logic [7:0] v = 8'($urandom);
      rx = 8'($urandom); st = 8'($urandom);
      if (op == 0) sp_wr(1'b1, v & 8'h7F);
      else if (op == 1) sp_wr(1'b0, v);
      else if (op == 2) sp_rd(1'b0, "R6 rand data");
      else sp_rd(1'b1, "R6 rand status");
    end
    chk_cfg("R5 rand");

    // R8/R9: interrupt handshake
    sp_wr(1'b1, 8'h80);
    pulse_done();
    chk("R8 irq set", irq_n, 1'b0);
    sp_rd(1'b1, "R9 status read");
    chk("R9 kept by status read", irq_n, 1'b0);
    sp_wr(1'b1, 8'h81); sp_wr(1'b0, 8'h33);
    chk("R9 kept by own write", irq_n, 1'b0);
    sp_wr(1'b1, 8'h80);
    sp_rd(1'b0, "R9 data read");
    chk("R9 cleared by data read", irq_n, 1'b1);
    pulse_done();
    chk("R8 irq set again", irq_n, 1'b0);
    sp_wr(1'b0, 8'h99);
    chk("R9 cleared by data write", irq_n, 1'b1);
    sp_wr(1'b1, 8'h00);
    pulse_done();
    chk("R8 disabled", irq_n, 1'b1);
    chk_cfg("R9");

    // R3/R4/R7: read/write-line mode
    do_reset();
    wr_n = 0; tick(4);
    chk("R3 mode selected", mrw, 1'b1);
    wr_n = 1; tick(4);
    a0 = 1; d_i = 8'h02; wr_n = 0; tick(1);
    cs_n = 0; tick(1);
    chk("R4 not yet enabled", dt_oe, 1'b0);
    tick(1);
    chk("R4 enabled", dt_oe, 1'b1);
    chk("R4 first cycle high", dt_o, 1'b1);
    tick(1);
    chk("R4 low one clock later", dt_o, 1'b0);
    tick(2);
    chk("R4 held low", dt_o, 1'b0);
    cs_n = 1; tick(2);
    chk("R4 released", dt_oe, 1'b0);
    wr_n = 1; tick(4);
    model_wr(1'b1, 8'h02);
    chk_cfg("R7 write ctrl");
    rw_wr(1'b0, 8'h6D);
    rw_wr(1'b1, 8'h00);
    rw_wr(1'b0, 8'hA5);
    chk_cfg("R7 writes");
    rw_rd(1'b0, "R7 rx read");
    rw_rd(1'b1, "R7 status read");
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v = 8'($urandom);
      rx = 8'($urandom); st = 8'($urandom);
      if ($urandom % 2 == 0) rw_wr(1'b0, v);
      else rw_rd(1'b0, "R7 rand read");
    end
    chk_cfg("R7 rand");
    // split-style sequence must not change the mode
    cs_n = 0; tick(2); wr_n = 0; tick(4); wr_n = 1; cs_n = 1; tick(4);
    chk("R3 stays", mrw, 1'b1);

    // R11: reset returns to split mode
    do_reset();
    chk("R11 mode", mrw, 1'b0);
    chk_cfg("R11");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule